// File: doc/BRIEF.md
# Banked Memory Map Chip-Select Decoder

This block sits between a processor with a 20-bit real-mode address space and the memories behind it, turning raw processor strobes into qualified selects. Memory accesses go to main DRAM, to one of two 64 KB frame-store banks (A or B), or to a 16 KB window into a paged flash disk. I/O accesses are decoded for a small bank of display control registers.

The frame-store window covers 0xA0000 to 0xBFFFF, and a 2-bit range code can narrow it at run time. When one 64 KB half is excluded, accesses to that half fall through to DRAM. Software uses this to save a screen by block-copying one half of the window onto the other. The flash window at 0xC8000 to 0xCBFFF is extended by an 8-bit page register into a 22-bit flash byte address. The top bit of the page register also lights a status LED.

All selects are combinational and valid in the same cycle as the address and strobes. Only the page register is clocked.

Top module: `banked_map_decoder`

## Requirements
- R1: After a synchronous reset the page register is zero, so flash_addr[21:14] reads 0 and status_led is low.
- R2: With range code 2'b00 (full window), a memory access in 0xA0000–0xAFFFF asserts fsa_sel and one in 0xB0000–0xBFFFF asserts fsb_sel; address bit 16 picks the bank (0 = A, 1 = B).
- R3: Range code 2'b01 enables only bank A, 2'b10 enables only bank B, and 2'b11 disables the frame store. An address in an excluded bank asserts no frame-store select and goes to DRAM instead.
- R4: dram_sel is asserted only on a memory access with dram_cs_raw high, an address at or below 0xBFFFF, and no frame-store select active.
- R5: A memory access in 0xC8000–0xCBFFF asserts flash_sel, and flash_addr equals {page[7:0], cpu_addr[13:0]} at all times.
- R6: The page register takes wr_data at a clock edge where both wr_stb and page_wr are high, and holds otherwise. The new value appears on flash_addr in the cycle after that edge.
- R7: status_led equals bit 7 of the page register.
- R8: An I/O access (io_cycle high) to port 0x0200–0x020F, decoded on cpu_addr[15:0], asserts disp_reg_sel. No memory select is asserted during an I/O access.
- R9: With neither rd_stb nor wr_stb high, no select is asserted. At most one of the five selects is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 20 | Processor byte address |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| io_cycle | input | 1 | High for an I/O-space access, low for a memory access |
| dram_cs_raw | input | 1 | Unqualified DRAM chip select from the processor |
| fs_range | input | 2 | Frame-store range code (00 full, 01 bank A, 10 bank B, 11 off) |
| page_wr | input | 1 | Select for loading the flash page register |
| wr_data | input | 8 | Data loaded into the page register |
| dram_sel | output | 1 | Qualified DRAM select |
| fsa_sel | output | 1 | Frame-store bank A select |
| fsb_sel | output | 1 | Frame-store bank B select |
| flash_sel | output | 1 | Flash window select |
| disp_reg_sel | output | 1 | Display register I/O select |
| flash_addr | output | 22 | Page and in-window offset for the flash device |
| status_led | output | 1 | Page register top bit, drives an LED |

## Verification
The five selects are combinational, so the bench drives each stimulus vector on a falling edge and compares the selects a nanosecond later, within the same cycle. A page-register write is presented before a rising edge and its effect on flash_addr and status_led is checked at the following falling edge, one cycle after the stimulus. Hold checks deassert one of the two load conditions across an edge and confirm flash_addr is unchanged at the next falling edge.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int unsigned MAP_ADDR_W  = 20;
    localparam int unsigned MAP_PAGE_W  = 8;
    localparam int unsigned MAP_WIN_W   = 14;
    localparam int unsigned MAP_BANK_BIT = 16;
    localparam int unsigned MAP_NUM_BANKS = 2;

    localparam logic [MAP_ADDR_W-1:0] MAP_FS_BASE    = 20'hA0000;
    localparam logic [MAP_ADDR_W-1:0] MAP_DRAM_TOP   = 20'hBFFFF;
    localparam logic [MAP_ADDR_W-1:0] MAP_FLASH_BASE = 20'hC8000;
    localparam logic [15:0]           MAP_IO_BASE    = 16'h0200;
    localparam int unsigned           MAP_IO_SPAN_W  = 4;

    typedef enum logic [1:0] {
        FS_FULL = 2'b00,
        FS_LOW  = 2'b01,
        FS_HIGH = 2'b10,
        FS_OFF  = 2'b11
    } fs_mode_e;

    typedef struct packed {
        logic dram;
        logic fsa;
        logic fsb;
        logic flash;
        logic disp;
    } sel_t;

    function automatic logic fs_bank_on(fs_mode_e mode, int unsigned bank);
        case (mode)
            FS_FULL: fs_bank_on = 1'b1;
            FS_LOW:  fs_bank_on = (bank == 0);
            FS_HIGH: fs_bank_on = (bank == 1);
            default: fs_bank_on = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int unsigned TAG_W = 6,
    parameter logic [TAG_W-1:0] BASE_TAG = '0
) (
    input  logic             en,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    always_comb begin
        hit = en && (tag == BASE_TAG);
    end
endmodule

// File: rtl/fs_window_decode.sv
module fs_window_decode import memmap_pkg::*; #(
    parameter int unsigned ADDR_W    = MAP_ADDR_W,
    parameter int unsigned BANK_BIT  = MAP_BANK_BIT,
    parameter int unsigned NUM_BANKS = MAP_NUM_BANKS,
    parameter logic [ADDR_W-1:0] BASE = MAP_FS_BASE
) (
    input  logic                   mem_acc,
    input  fs_mode_e               mode,
    input  logic [ADDR_W-1:BANK_BIT] addr_hi,
    output logic [NUM_BANKS-1:0]   bank_sel,
    output logic                   hit
);
    localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned TOP_W = ADDR_W - BANK_BIT - IDX_W;

    logic [TOP_W-1:0] top_tag;
    logic [IDX_W-1:0] bank_idx;
    logic             in_window;

    always_comb begin
        top_tag   = addr_hi[ADDR_W-1:BANK_BIT+IDX_W];
        bank_idx  = addr_hi[BANK_BIT+IDX_W-1:BANK_BIT];
        in_window = mem_acc && (top_tag == BASE[ADDR_W-1:BANK_BIT+IDX_W]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            bank_sel[b] = in_window
                       && (bank_idx == IDX_W'(b))
                       && fs_bank_on(mode, b);
        end
    end

    always_comb begin
        hit = |bank_sel;
    end
endmodule

// File: rtl/flash_page_latch.sv
module flash_page_latch #(
    parameter int unsigned PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (load) begin
            page <= din;
        end
    end
endmodule

// File: rtl/banked_map_decoder.sv
module banked_map_decoder import memmap_pkg::*; #(
    parameter int unsigned ADDR_W   = MAP_ADDR_W,
    parameter int unsigned PAGE_W   = MAP_PAGE_W,
    parameter int unsigned WIN_W    = MAP_WIN_W,
    parameter int unsigned BANK_BIT = MAP_BANK_BIT,
    parameter logic [ADDR_W-1:0] FS_BASE    = MAP_FS_BASE,
    parameter logic [ADDR_W-1:0] DRAM_TOP   = MAP_DRAM_TOP,
    parameter logic [ADDR_W-1:0] FLASH_BASE = MAP_FLASH_BASE,
    parameter logic [15:0]       IO_BASE    = MAP_IO_BASE,
    parameter int unsigned       IO_SPAN_W  = MAP_IO_SPAN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic                    io_cycle,
    input  logic                    dram_cs_raw,
    input  logic [1:0]              fs_range,
    input  logic                    page_wr,
    input  logic [PAGE_W-1:0]       wr_data,
    output logic                    dram_sel,
    output logic                    fsa_sel,
    output logic                    fsb_sel,
    output logic                    flash_sel,
    output logic                    disp_reg_sel,
    output logic [PAGE_W+WIN_W-1:0] flash_addr,
    output logic                    status_led
);
    localparam int unsigned NUM_BANKS = MAP_NUM_BANKS;
    localparam int unsigned FL_TAG_W  = ADDR_W - WIN_W;
    localparam int unsigned IO_TAG_W  = 16 - IO_SPAN_W;

    logic                 access;
    logic                 mem_acc;
    logic                 io_acc;
    logic [NUM_BANKS-1:0] fs_bank;
    logic                 fs_hit;
    logic                 flash_hit;
    logic                 io_hit;
    logic                 dram_range;
    logic [PAGE_W-1:0]    page_q;
    fs_mode_e             fs_mode;
    sel_t                 sel;

    always_comb begin
        access     = rd_stb || wr_stb;
        mem_acc    = access && !io_cycle;
        io_acc     = access && io_cycle;
        fs_mode    = fs_mode_e'(fs_range);
        dram_range = (cpu_addr <= DRAM_TOP);
    end

    fs_window_decode #(
        .ADDR_W    (ADDR_W),
        .BANK_BIT  (BANK_BIT),
        .NUM_BANKS (NUM_BANKS),
        .BASE      (FS_BASE)
    ) u_fs (
        .mem_acc  (mem_acc),
        .mode     (fs_mode),
        .addr_hi  (cpu_addr[ADDR_W-1:BANK_BIT]),
        .bank_sel (fs_bank),
        .hit      (fs_hit)
    );

    region_match #(
        .TAG_W    (FL_TAG_W),
        .BASE_TAG (FLASH_BASE[ADDR_W-1:WIN_W])
    ) u_flash_win (
        .en  (mem_acc),
        .tag (cpu_addr[ADDR_W-1:WIN_W]),
        .hit (flash_hit)
    );

    region_match #(
        .TAG_W    (IO_TAG_W),
        .BASE_TAG (IO_BASE[15:IO_SPAN_W])
    ) u_io_win (
        .en  (io_acc),
        .tag (cpu_addr[15:IO_SPAN_W]),
        .hit (io_hit)
    );

    flash_page_latch #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk  (clk),
        .rst  (rst),
        .load (wr_stb && page_wr),
        .din  (wr_data),
        .page (page_q)
    );

    always_comb begin
        sel.fsa   = fs_bank[0];
        sel.fsb   = fs_bank[1];
        sel.dram  = mem_acc && dram_cs_raw && dram_range && !fs_hit;
        sel.flash = flash_hit;
        sel.disp  = io_hit;
    end

    always_comb begin
        dram_sel     = sel.dram;
        fsa_sel      = sel.fsa;
        fsb_sel      = sel.fsb;
        flash_sel    = sel.flash;
        disp_reg_sel = sel.disp;
        flash_addr   = {page_q, cpu_addr[WIN_W-1:0]};
        status_led   = page_q[PAGE_W-1];
    end
endmodule

// File: rtl/map_checker.sv
module map_checker #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned FA_W   = 22,
    parameter int unsigned PAGE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              io_cycle,
    input logic [1:0]        fs_range,
    input logic              page_wr,
    input logic [PAGE_W-1:0] wr_data,
    input logic              dram_sel,
    input logic              fsa_sel,
    input logic              fsb_sel,
    input logic              flash_sel,
    input logic              disp_reg_sel,
    input logic [FA_W-1:0]   flash_addr,
    input logic              status_led
);
    // R9: selects mutually exclusive
    a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dram_sel, fsa_sel, fsb_sel, flash_sel, disp_reg_sel}));

    // R9: no strobe, no select
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb || wr_stb) |-> !(dram_sel || fsa_sel || fsb_sel || flash_sel || disp_reg_sel));

    // R3: range code 11 keeps both banks off
    a_r3_fs_off: assert property (@(posedge clk) disable iff (rst)
        (fs_range == 2'b11) |-> !(fsa_sel || fsb_sel));

    // R8: I/O cycles raise no memory select
    a_r8_io_no_mem: assert property (@(posedge clk) disable iff (rst)
        io_cycle |-> !(dram_sel || fsa_sel || fsb_sel || flash_sel));

    // R5: flash offset follows the processor address
    a_r5_flash_offset: assert property (@(posedge clk) disable iff (rst)
        flash_sel |-> (flash_addr[13:0] == cpu_addr[13:0] && cpu_addr[19:14] == 6'h32));

    // R6: loaded value appears one cycle later
    a_r6_page_load: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && page_wr) |=> (flash_addr[FA_W-1:FA_W-PAGE_W] == $past(wr_data)));

    // R6: page holds without a load
    a_r6_page_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && page_wr) |=> $stable(flash_addr[FA_W-1:FA_W-PAGE_W]));

    // R7: LED rises only after a load of a value with the top bit set
    a_r7_led_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(status_led) |-> $past(wr_stb && page_wr && wr_data[PAGE_W-1]));
endmodule

bind banked_map_decoder map_checker #(
    .ADDR_W (ADDR_W),
    .FA_W   (PAGE_W + WIN_W),
    .PAGE_W (PAGE_W)
) u_map_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .io_cycle     (io_cycle),
    .fs_range     (fs_range),
    .page_wr      (page_wr),
    .wr_data      (wr_data),
    .dram_sel     (dram_sel),
    .fsa_sel      (fsa_sel),
    .fsb_sel      (fsb_sel),
    .flash_sel    (flash_sel),
    .disp_reg_sel (disp_reg_sel),
    .flash_addr   (flash_addr),
    .status_led   (status_led)
);

// File: tb/sim_banked_map_decoder.sv
`timescale 1ns/1ps
module sim_banked_map_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] cpu_addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        io_cycle = 1'b0;
    logic        dram_cs_raw = 1'b0;
    logic [1:0]  fs_range = 2'b00;
    logic        page_wr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        dram_sel, fsa_sel, fsb_sel, flash_sel, disp_reg_sel;
    logic [21:0] flash_addr;
    logic        status_led;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    banked_map_decoder u0 (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .io_cycle     (io_cycle),
        .dram_cs_raw  (dram_cs_raw),
        .fs_range     (fs_range),
        .page_wr      (page_wr),
        .wr_data      (wr_data),
        .dram_sel     (dram_sel),
        .fsa_sel      (fsa_sel),
        .fsb_sel      (fsb_sel),
        .flash_sel    (flash_sel),
        .disp_reg_sel (disp_reg_sel),
        .flash_addr   (flash_addr),
        .status_led   (status_led)
    );

    // vector: {req[3:0], io, rd, wr, draw, range[1:0], addr[19:0], exp{dram,fsa,fsb,flash,disp}}
    localparam int NV = 20;
    function automatic logic [34:0] v(input logic [3:0] rq, input logic io, input logic rd,
                                      input logic wr, input logic dr, input logic [1:0] rg,
                                      input logic [19:0] ad, input logic [4:0] ex);
        v = {rq, io, rd, wr, dr, rg, ad, ex};
    endfunction

    localparam logic [34:0] VEC [0:NV-1] = '{
        v(4'd2, 0,1,0,1, 2'b00, 20'hA1234, 5'b01000), // R2 bank A
        v(4'd2, 0,1,0,1, 2'b00, 20'hB8000, 5'b00100), // R2 bank B
        v(4'd2, 0,0,1,1, 2'b00, 20'hBFFFF, 5'b00100), // R2 write, top of B
        v(4'd4, 0,1,0,1, 2'b00, 20'h50000, 5'b10000), // R4 plain DRAM
        v(4'd4, 0,1,0,1, 2'b00, 20'h9FFFF, 5'b10000), // R4 just below window
        v(4'd3, 0,1,0,1, 2'b01, 20'hA0000, 5'b01000), // R3 lower only keeps A
        v(4'd3, 0,1,0,1, 2'b01, 20'hBFFFF, 5'b10000), // R3 B falls to DRAM
        v(4'd3, 0,1,0,1, 2'b10, 20'hAFFFF, 5'b10000), // R3 A falls to DRAM
        v(4'd3, 0,1,0,1, 2'b10, 20'hB0000, 5'b00100), // R3 upper only keeps B
        v(4'd3, 0,1,0,1, 2'b11, 20'hA5555, 5'b10000), // R3 disabled
        v(4'd3, 0,1,0,1, 2'b11, 20'hB5555, 5'b10000), // R3 disabled
        v(4'd4, 0,1,0,0, 2'b01, 20'hB0000, 5'b00000), // R4 raw select low
        v(4'd4, 0,1,0,1, 2'b00, 20'hC0000, 5'b00000), // R4 above DRAM top
        v(4'd5, 0,1,0,0, 2'b00, 20'hC8000, 5'b00010), // R5 flash bottom
        v(4'd5, 0,0,1,0, 2'b00, 20'hCBFFF, 5'b00010), // R5 flash top
        v(4'd5, 0,1,0,0, 2'b00, 20'hCC000, 5'b00000), // R5 just above
        v(4'd8, 1,1,0,1, 2'b00, 20'h00205, 5'b00001), // R8 display reg
        v(4'd8, 1,0,1,1, 2'b00, 20'h00210, 5'b00000), // R8 just above
        v(4'd8, 1,1,0,1, 2'b00, 20'hA0000, 5'b00000), // R8 io with memory address
        v(4'd9, 0,0,0,1, 2'b00, 20'hA0000, 5'b00000)  // R9 no strobe
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] sels();
        sels = {dram_sel, fsa_sel, fsb_sel, flash_sel, disp_reg_sel};
    endfunction

    task automatic load_page(input logic [7:0] d, input logic pw, input logic ws);
        @(negedge clk);
        page_wr = pw; wr_stb = ws; wr_data = d; rd_stb = 1'b0; io_cycle = 1'b1;
        cpu_addr = 20'h00300;
        @(negedge clk);
        page_wr = 1'b0; wr_stb = 1'b0; io_cycle = 1'b0;
    endtask

    task automatic flash_read(input logic [19:0] a);
        rd_stb = 1'b1; io_cycle = 1'b0; dram_cs_raw = 1'b0; cpu_addr = a;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check(flash_addr[21:14] == 8'h00, "R1 page", 32'(flash_addr[21:14]), 32'h0);
        check(status_led == 1'b0, "R1 led", 32'(status_led), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {io_cycle, rd_stb, wr_stb, dram_cs_raw, fs_range, cpu_addr} = VEC[i][30:5];
            #1;
            check(sels() == VEC[i][4:0], $sformatf("R%0d vec%0d", VEC[i][34:31], i),
                  32'(sels()), 32'(VEC[i][4:0]));
            check($onehot0(sels()), "R9 onehot", 32'(sels()), 32'(VEC[i][4:0]));
        end

        // R6 load then R5 composite address
        load_page(8'h5A, 1'b1, 1'b1);
        flash_read(20'hCA123);
        check(flash_addr == {8'h5A, 14'h2123}, "R5 R6 address", 32'(flash_addr), 32'h16A123);
        check(flash_sel == 1'b1, "R5 sel", 32'(flash_sel), 32'h1);
        check(status_led == 1'b0, "R7 led low", 32'(status_led), 32'h0);

        // R6 hold: select without strobe, strobe without select
        load_page(8'hFF, 1'b1, 1'b0);
        flash_read(20'hCA123);
        check(flash_addr[21:14] == 8'h5A, "R6 hold no strobe", 32'(flash_addr[21:14]), 32'h5A);
        load_page(8'hFF, 1'b0, 1'b1);
        flash_read(20'hCA123);
        check(flash_addr[21:14] == 8'h5A, "R6 hold no select", 32'(flash_addr[21:14]), 32'h5A);

        // R7 top bit drives the LED
        load_page(8'h80, 1'b1, 1'b1);
        check(status_led == 1'b1, "R7 led high", 32'(status_led), 32'h1);
        check(flash_addr[21:14] == 8'h80, "R6 page 80", 32'(flash_addr[21:14]), 32'h80);

        // R5 largest page and top of window
        load_page(8'hFF, 1'b1, 1'b1);
        flash_read(20'hCBFFF);
        check(flash_addr == 22'h3FFFFF, "R5 max address", 32'(flash_addr), 32'h3FFFFF);

        // R1 reset mid-run clears the page
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(flash_addr[21:14] == 8'h00, "R1 page after reset", 32'(flash_addr[21:14]), 32'h0);
        check(status_led == 1'b0, "R1 led after reset", 32'(status_led), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule